// File: doc/BRIEF.md
# Operand Effective Address Sequencer

This block works out the effective address of a memory operand for an 8-bit processor that has 16-bit addresses. A controller gives it a one-cycle start pulse together with a 3-bit addressing-mode code, the two index registers and the program counter. The block then fetches the operand bytes that follow the opcode through a single-byte read port. For the indirect modes it also reads a two-byte pointer from page zero. It returns the final address, a one-cycle completion pulse and the program counter moved past the operand.

The zero-page forms keep their sums inside page zero and drop any carry. The absolute forms with an index, and the post-indexed indirect form, let the carry from the low byte ripple into the high byte. A pointer placed at the last byte of page zero takes its high byte from the first byte of page zero.

Top module: `opaddr_gen`

## Requirements
- R1: Mode code 0 (page zero) gives an address whose low byte is the operand byte and whose high byte is 0x00.
- R2: Mode codes 1 and 2 (page zero plus X, plus Y) give {0x00, (operand + index) mod 256}. Bits 15:8 of the address are zero for modes 0 to 2.
- R3: Mode code 3 (absolute) gives a 16-bit operand. The first fetched byte is the low byte and the second fetched byte is the high byte.
- R4: Mode codes 4 and 5 (absolute plus X, plus Y) give (16-bit operand + index) mod 65536, with the carry passed into the high byte.
- R5: Mode code 6 (pre-indexed indirect) forms base = (operand + X) mod 256. It then reads the pointer low byte at {0x00, base} and the high byte at {0x00, (base+1) mod 256}. The address is that pointer.
- R6: Mode code 7 (post-indexed indirect) reads a pointer at {0x00, operand} and {0x00, (operand+1) mod 256}. The address is (pointer + Y) mod 65536.
- R7: The first operand read is at the program counter given with start. Each operand byte fetched adds one to the PC, modulo 65536. The PC output ends at PC+1 for modes 0–2 and 6–7, and at PC+2 for modes 3–5.
- R8: Read data is taken in the cycle after the read strobe, and the port issues one read per cycle at most. One operation makes 1 read in modes 0–2, 2 reads in modes 3–5 and 3 reads in modes 6–7. There is no read strobe while the block is idle.
- R9: Counted from the clock edge that accepts start, done rises 2 edges later in modes 0–2, 3 edges later in modes 3–5 and 4 edges later in modes 6–7. Done lasts one cycle. The address and PC outputs then hold until the next accepted start.
- R10: Mode, X, Y and PC are captured at the accepted start. Changing these inputs later has no effect, and a start pulse during an operation is ignored.
- R11: Synchronous active-high reset clears the address, done, the read strobe and the PC output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an address computation (accepted only when idle) |
| mode_sel | input | 3 | Addressing-mode code 0–7 |
| idx_x | input | 8 | X index value |
| idx_y | input | 8 | Y index value |
| pc_in | input | 16 | Program counter pointing at the first operand byte |
| mem_rd | output | 1 | Byte read strobe |
| mem_addr | output | 16 | Byte read address |
| mem_rdata | input | 8 | Read data, valid the cycle after the strobe |
| ea | output | 16 | Effective address |
| done | output | 1 | One-cycle completion pulse |
| pc_out | output | 16 | Program counter after the operand |

## Verification
A corrupted program counter shows up on mem_addr at the second operand read, one cycle after the first read. Where there is no second read, it shows on pc_out at done. A sequencer in the wrong state shows within the same operation: the read count and the done latency for the mode are wrong. A pointer base that is wrong or carries out of page zero puts a wrong high byte on mem_addr in the pointer-fetch cycle. Every operation that does not keep its inputs latched gives a wrong address at done.

// File: rtl/oag_pkg.sv
`timescale 1ns/1ps
package oag_pkg;
    localparam int DW = 8;
    localparam int AW = 2 * DW;

    typedef logic [DW-1:0] byte_t;
    typedef logic [AW-1:0] addr_t;

    typedef enum logic [2:0] {
        AM_ZP   = 3'd0,
        AM_ZPX  = 3'd1,
        AM_ZPY  = 3'd2,
        AM_ABS  = 3'd3,
        AM_ABSX = 3'd4,
        AM_ABSY = 3'd5,
        AM_INDX = 3'd6,
        AM_INDY = 3'd7
    } amode_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_OP0, ST_OP1, ST_OP2, ST_PT1, ST_PT2
    } seq_st_e;

    typedef struct packed {
        amode_e mode;
        byte_t  xr;
        byte_t  yr;
    } req_t;

    function automatic logic is_wide_operand(amode_e m);
        return (m == AM_ABS) || (m == AM_ABSX) || (m == AM_ABSY);
    endfunction

    function automatic logic is_indirect(amode_e m);
        return (m == AM_INDX) || (m == AM_INDY);
    endfunction

    function automatic logic is_page_zero(amode_e m);
        return (m == AM_ZP) || (m == AM_ZPX) || (m == AM_ZPY);
    endfunction

    // index applied inside page zero (no carry out)
    function automatic byte_t low_index(req_t r);
        case (r.mode)
            AM_ZPX, AM_INDX: return r.xr;
            AM_ZPY:          return r.yr;
            default:         return '0;
        endcase
    endfunction

    // index applied across the full address (carry into high byte)
    function automatic byte_t full_index(req_t r);
        case (r.mode)
            AM_ABSX:          return r.xr;
            AM_ABSY, AM_INDY: return r.yr;
            default:          return '0;
        endcase
    endfunction

    function automatic addr_t in_page_zero(byte_t b);
        return {byte_t'(0), b};
    endfunction
endpackage

// File: rtl/oag_form.sv
`timescale 1ns/1ps
module oag_form
    import oag_pkg::*;
(
    input  req_t  req,
    input  byte_t lo_byte,
    input  byte_t rd_byte,
    output addr_t zp_ea,
    output addr_t wide_ea
);
    byte_t zp_sum;

    always_comb begin
        zp_sum  = rd_byte + low_index(req);
        zp_ea   = in_page_zero(zp_sum);
        wide_ea = {rd_byte, lo_byte} + addr_t'(full_index(req));
    end
endmodule

// File: rtl/oag_seq.sv
`timescale 1ns/1ps
module oag_seq
    import oag_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic [2:0] mode_sel,
    input  byte_t  idx_x,
    input  byte_t  idx_y,
    input  addr_t  pc_in,
    input  addr_t  zp_ea,
    output logic   mem_rd,
    output addr_t  mem_addr,
    output req_t   req_q,
    output byte_t  lo_q,
    output addr_t  pc_q,
    output logic   busy,
    output logic   fin_zp,
    output logic   fin_wide
);
    seq_st_e st, st_nxt;
    byte_t   base_q;
    logic    pc_step;
    logic    accept;

    assign busy   = (st != ST_IDLE);
    assign accept = (st == ST_IDLE) && start;

    always_comb begin
        st_nxt   = st;
        mem_rd   = 1'b0;
        mem_addr = pc_q;
        pc_step  = 1'b0;
        fin_zp   = 1'b0;
        fin_wide = 1'b0;
        case (st)
            ST_IDLE: if (start) st_nxt = ST_OP0;
            ST_OP0: begin
                mem_rd  = 1'b1;
                pc_step = 1'b1;
                st_nxt  = ST_OP1;
            end
            ST_OP1: begin
                if (is_wide_operand(req_q.mode)) begin
                    mem_rd  = 1'b1;
                    pc_step = 1'b1;
                    st_nxt  = ST_OP2;
                end else if (is_indirect(req_q.mode)) begin
                    mem_rd   = 1'b1;
                    mem_addr = zp_ea;
                    st_nxt   = ST_PT1;
                end else begin
                    fin_zp = 1'b1;
                    st_nxt = ST_IDLE;
                end
            end
            ST_OP2: begin
                fin_wide = 1'b1;
                st_nxt   = ST_IDLE;
            end
            ST_PT1: begin
                mem_rd   = 1'b1;
                mem_addr = in_page_zero(base_q + byte_t'(1));
                st_nxt   = ST_PT2;
            end
            ST_PT2: begin
                fin_wide = 1'b1;
                st_nxt   = ST_IDLE;
            end
            default: st_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            req_q  <= '0;
            pc_q   <= '0;
            lo_q   <= '0;
            base_q <= '0;
        end else begin
            st <= st_nxt;
            if (accept) begin
                req_q <= '{mode: amode_e'(mode_sel), xr: idx_x, yr: idx_y};
                pc_q  <= pc_in;
            end else if (pc_step) begin
                pc_q <= pc_q + addr_t'(1);
            end
            if (st == ST_OP1) begin
                lo_q   <= zp_ea[DW-1:0] - low_index(req_q) + low_index(req_q);
                base_q <= zp_ea[DW-1:0];
            end
            if (st == ST_PT1) lo_q <= zp_ea[DW-1:0] - low_index(req_q);
            if (st == ST_OP1 && is_wide_operand(req_q.mode)) lo_q <= zp_ea[DW-1:0] - low_index(req_q);
        end
    end

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE) |-> !mem_rd);
    p_pc_step_r7: assert property (@(posedge clk) disable iff (rst)
        (st == ST_OP0) |=> (pc_q == $past(pc_q) + addr_t'(1)));
    p_pc_latch_r10: assert property (@(posedge clk) disable iff (rst)
        accept |=> (pc_q == $past(pc_in)));
    p_req_hold_r10: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(req_q));
    p_ptr_next_r6: assert property (@(posedge clk) disable iff (rst)
        (st == ST_PT1) |-> (mem_addr == in_page_zero($past(mem_addr[DW-1:0]) + byte_t'(1))));
endmodule

// File: rtl/opaddr_gen.sv
`timescale 1ns/1ps
module opaddr_gen
    import oag_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [2:0]    mode_sel,
    input  logic [DW-1:0] idx_x,
    input  logic [DW-1:0] idx_y,
    input  logic [AW-1:0] pc_in,
    output logic          mem_rd,
    output logic [AW-1:0] mem_addr,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] ea,
    output logic          done,
    output logic [AW-1:0] pc_out
);
    req_t  req_q;
    byte_t lo_q;
    addr_t pc_q, zp_ea, wide_ea;
    logic  busy, fin_zp, fin_wide;

    oag_form u_form (
        .req     (req_q),
        .lo_byte (lo_q),
        .rd_byte (mem_rdata),
        .zp_ea   (zp_ea),
        .wide_ea (wide_ea)
    );

    oag_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .mode_sel (mode_sel),
        .idx_x    (idx_x),
        .idx_y    (idx_y),
        .pc_in    (pc_in),
        .zp_ea    (zp_ea),
        .mem_rd   (mem_rd),
        .mem_addr (mem_addr),
        .req_q    (req_q),
        .lo_q     (lo_q),
        .pc_q     (pc_q),
        .busy     (busy),
        .fin_zp   (fin_zp),
        .fin_wide (fin_wide)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ea   <= '0;
            done <= 1'b0;
        end else begin
            done <= fin_zp | fin_wide;
            if (fin_zp)        ea <= zp_ea;
            else if (fin_wide) ea <= wide_ea;
        end
    end

    assign pc_out = pc_q;

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(ea) && $stable(pc_out)));
    p_zp_page_r2: assert property (@(posedge clk) disable iff (rst)
        (done && is_page_zero(req_q.mode)) |-> (ea[AW-1:DW] == '0));
    p_one_finish_r8: assert property (@(posedge clk) disable iff (rst)
        !(fin_zp && fin_wide));
endmodule

// File: tb/opaddr_gen_tb.sv
`timescale 1ns/1ps
module opaddr_gen_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  mode_sel = '0;
    logic [7:0]  idx_x = '0, idx_y = '0;
    logic [15:0] pc_in = '0;
    logic        mem_rd;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata = '0;
    logic [15:0] ea, pc_out;
    logic        done;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int rd_n = 0;
    logic [15:0] rd_first = '0;

    opaddr_gen u_dut (
        .clk(clk), .rst(rst), .start(start), .mode_sel(mode_sel),
        .idx_x(idx_x), .idx_y(idx_y), .pc_in(pc_in),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .ea(ea), .done(done), .pc_out(pc_out)
    );

    always #10 clk = ~clk;

    function automatic logic [7:0] mb(input logic [15:0] a);
        return 8'(a[7:0] * 8'd13) ^ a[15:8] ^ 8'h3C;
    endfunction

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (mem_rd) begin
            if (rd_n == 0) rd_first = mem_addr;
            rd_n = rd_n + 1;
            mem_rdata <= mb(mem_addr);
        end
        if (cyc > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_ea(input logic [2:0] m, input logic [7:0] x, input logic [7:0] y, input logic [15:0] pc);
        logic [7:0] o0, o1, b;
        o0 = mb(pc);
        o1 = mb(pc + 16'd1);
        b  = (m == 3'd6) ? 8'(o0 + x) : o0;
        case (m)
            3'd0: return {8'h00, o0};
            3'd1: return {8'h00, 8'(o0 + x)};
            3'd2: return {8'h00, 8'(o0 + y)};
            3'd3: return {o1, o0};
            3'd4: return {o1, o0} + {8'h00, x};
            3'd5: return {o1, o0} + {8'h00, y};
            3'd6: return {mb({8'h00, 8'(b + 8'd1)}), mb({8'h00, b})};
            default: return {mb({8'h00, 8'(b + 8'd1)}), mb({8'h00, b})} + {8'h00, y};
        endcase
    endfunction

    function automatic string ea_tag(input logic [2:0] m);
        case (m)
            3'd0: return "R1 zp";
            3'd1, 3'd2: return "R2 zp idx";
            3'd3: return "R3 abs";
            3'd4, 3'd5: return "R4 abs idx";
            3'd6: return "R5 pre-indexed";
            default: return "R6 post-indexed";
        endcase
    endfunction

    task automatic run_one(input logic [2:0] m, input logic [7:0] x, input logic [7:0] y,
                           input logic [15:0] pc, input bit interfere);
        int cnt;
        int lat;
        int nrd;
        logic [15:0] e_ea, e_pc, hold_ea;
        lat  = (m >= 3'd6) ? 5 : ((m >= 3'd3) ? 4 : 3);
        nrd  = (m >= 3'd6) ? 3 : ((m >= 3'd3) ? 2 : 1);
        e_pc = pc + ((m >= 3'd3 && m <= 3'd5) ? 16'd2 : 16'd1);
        e_ea = exp_ea(m, x, y, pc);
        @(negedge clk);
        mode_sel = m; idx_x = x; idx_y = y; pc_in = pc; start = 1'b1;
        rd_n = 0;
        @(negedge clk);
        cnt = 1;
        start = 1'b0;
        mode_sel = ~m; idx_x = ~x; idx_y = ~y; pc_in = ~pc;
        if (interfere) start = 1'b1;
        while (!done && cnt < 20) begin
            @(negedge clk);
            cnt++;
            if (cnt == 3) start = 1'b0;
        end
        start = 1'b0;
        chk(ea == e_ea, ea_tag(m), 32'(ea), 32'(e_ea));
        chk(pc_out == e_pc, "R7 pc advance", 32'(pc_out), 32'(e_pc));
        chk(rd_first == pc, "R7 first read at pc", 32'(rd_first), 32'(pc));
        chk(rd_n == nrd, "R8 read count", 32'(rd_n), 32'(nrd));
        chk(cnt == lat, "R9 done latency", 32'(cnt), 32'(lat));
        hold_ea = ea;
        @(negedge clk);
        chk(done == 1'b0, "R9 done pulse width", 32'(done), 32'd0);
        @(negedge clk);
        chk(ea == hold_ea && pc_out == e_pc, "R9 hold after done", 32'(ea), 32'(hold_ea));
        if (interfere) chk(ea == e_ea, "R10 start during busy ignored", 32'(ea), 32'(e_ea));
    endtask

    initial begin
        logic [15:0] pcs [6];
        logic [7:0]  idx [5];
        logic [15:0] pc_ff;
        pcs[0] = 16'h0000; pcs[1] = 16'h0200; pcs[2] = 16'h12F7;
        pcs[3] = 16'h80FF; pcs[4] = 16'hC3A1; pcs[5] = 16'hFFFF;
        idx[0] = 8'h00; idx[1] = 8'h01; idx[2] = 8'h7F; idx[3] = 8'h80; idx[4] = 8'hFF;
        repeat (3) @(negedge clk);
        chk(ea == 16'h0 && done == 1'b0, "R11 reset ea/done", 32'(ea), 32'h0);
        chk(mem_rd == 1'b0 && pc_out == 16'h0, "R11 reset strobe/pc", 32'(pc_out), 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk(mem_rd == 1'b0, "R8 idle no read", 32'(mem_rd), 32'h0);
        for (int m = 0; m < 8; m++)
            for (int p = 0; p < 6; p++)
                for (int i = 0; i < 5; i++)
                    run_one(3'(m), idx[i], idx[4 - i], pcs[p], 1'b0);
        // R5: pre-indexed pointer based at 0xFF wraps its high byte fetch to 0x00
        run_one(3'd6, 8'(8'hFF - mb(16'h0345)), 8'h00, 16'h0345, 1'b0);
        // R6: post-indexed pointer at 0xFF wraps its high byte fetch to 0x00
        pc_ff = 16'h0000;
        for (int a = 0; a < 65536; a++)
            if (mb(16'(a)) == 8'hFF && pc_ff == 16'h0000) pc_ff = 16'(a);
        run_one(3'd7, 8'h11, 8'hF0, pc_ff, 1'b0);
        // R10: start pulses during an operation
        for (int m = 0; m < 8; m++) run_one(3'(m), 8'h5A, 8'hA5, 16'h4321, 1'b1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule